// File: doc/BRIEF.md
# Bidirectional Pad Test-Direction Controller

This block sits between the core and a bank of bidirectional pads. It decides, for every pad, whether the output driver is on and which value it drives. In mission mode it passes the core's requests straight through. In test mode a few shared pads are given fixed scan roles: some pads carry scan chain outputs off the chip and others bring scan chain inputs in. While scan-enable is high, each pad is steered to the direction that its scan role needs. A global inhibit input can switch every driver off at once.

For stuck-at capture, a small sequencer runs each pattern through three phases. In the first phase the pads take the direction the pattern asks for. In the second phase every pad is switched to input. In the third phase the pads stay inputs and the capture clock enable pulses once. Bus values that the tester drove in the first phase are therefore captured through the pad inputs, and no driver ever contends on a bidirectional bus. A done flag marks the end of each capture.

Top module: `padtest_dir_ctrl`

## Requirements
- R1: With `test_mode` low, `pad_oe` equals `core_oe` and `pad_do` equals `core_do`. `scan_en`, `tri_inhibit` and `cap_start` have no effect: no capture sequence starts and `cap_clk_en` stays low.
- R2: With `test_mode` high and `tri_inhibit` high, every bit of `pad_oe` is 0. This holds during shift as well.
- R3: With `test_mode` and `scan_en` high and `tri_inhibit` low, outside the wait and clock phases, the scan-out pads (indices `SO_BASE` to `SO_BASE+NUM_CHAINS-1`, pad `SO_BASE+k` for chain k) have `pad_oe`=1 and `pad_do`=`chain_so[k]`. Every other pad, scan-in pads included, has `pad_oe`=0.
- R4: `chain_si[k]` always equals `pad_di[SI_BASE+k]`.
- R5: A `cap_start` pulse sampled while `test_mode` is high and the sequencer is idle enters the strobe phase at the next clock. The wait phase, then the clock phase, follow on successive clocks, and then the sequencer returns to idle. A `cap_start` sampled while a capture is running is ignored.
- R6: In the strobe phase, with `scan_en` and `tri_inhibit` low, `pad_oe` equals `core_oe`.
- R7: In the wait phase and the clock phase, with `test_mode` high, every bit of `pad_oe` is 0.
- R8: `cap_clk_en` is 1 in the clock phase only, that is, for exactly one cycle per capture: the third cycle after the clock edge that sampled `cap_start`.
- R9: `cap_done` is 1 for exactly one cycle, the cycle after the clock phase.
- R10: With `test_mode` high, `scan_en` low, `tri_inhibit` low and the sequencer idle, `pad_oe` equals `core_oe` and `pad_do` equals `core_do`.
- R11: A low `rst_n` sampled at a clock edge returns the sequencer to idle, with `cap_clk_en` and `cap_done` at 0, even in the middle of a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | Static test-mode select |
| scan_en | input | 1 | Marks scan shift cycles |
| tri_inhibit | input | 1 | Global driver inhibit; all pads become inputs |
| cap_start | input | 1 | One-cycle pulse that starts a capture sequence |
| core_oe | input | NUM_PADS | Core output-enable requests |
| core_do | input | NUM_PADS | Core output data |
| chain_so | input | NUM_CHAINS | Scan chain output bits |
| pad_di | input | NUM_PADS | Data received from the pads |
| pad_oe | output | NUM_PADS | Pad driver enables |
| pad_do | output | NUM_PADS | Pad output data |
| chain_si | output | NUM_CHAINS | Scan chain input taps |
| cap_clk_en | output | 1 | Capture clock enable |
| cap_done | output | 1 | One-cycle end-of-capture flag |

## Verification
Two overlaps are provoked deliberately. In the first, the global inhibit is raised in the same cycles as scan-enable. Both inputs are held high together over several data patterns, and the bench expects every driver to be off while the scan-out pads still present the chain data. In the second, scan-enable is high while the sequencer is in its wait phase. The bench judges that the phase, not the shift, decides the enables, and it sets a mask with the scan-out bits on as the core request so that the phase must clear it.

// File: rtl/padtest_pkg.sv
package padtest_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_STROBE = 2'd1,
      PH_WAIT   = 2'd2,
      PH_CLOCK  = 2'd3
   } cap_phase_e;

   typedef enum logic [1:0] {
      ROLE_PLAIN = 2'd0,
      ROLE_SO    = 2'd1,
      ROLE_SI    = 2'd2
   } pad_role_e;

   function automatic pad_role_e role_of(input int idx, input int so_base,
                                         input int si_base, input int nch);
      if (idx >= so_base && idx < so_base + nch) return ROLE_SO;
      if (idx >= si_base && idx < si_base + nch) return ROLE_SI;
      return ROLE_PLAIN;
   endfunction

endpackage

// File: rtl/padtest_phase_seq.sv
module padtest_phase_seq
   import padtest_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_ok,
   output cap_phase_e phase,
   output logic       seq_inhibit,
   output logic       cap_clk_en,
   output logic       cap_done
);

   cap_phase_e phase_q, phase_d;
   logic       done_q;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:   if (start_ok) phase_d = PH_STROBE;
         PH_STROBE: phase_d = PH_WAIT;
         PH_WAIT:   phase_d = PH_CLOCK;
         PH_CLOCK:  phase_d = PH_IDLE;
         default:   phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= (phase_q == PH_CLOCK);
      end
   end

   assign phase       = phase_q;
   assign seq_inhibit = (phase_q == PH_WAIT) || (phase_q == PH_CLOCK);
   assign cap_clk_en  = (phase_q == PH_CLOCK);
   assign cap_done    = done_q;

endmodule

// File: rtl/padtest_pad_slice.sv
module padtest_pad_slice
   import padtest_pkg::*;
#(
   parameter pad_role_e ROLE = ROLE_PLAIN
) (
   input  logic test_mode,
   input  logic shift,
   input  logic force_in,
   input  logic core_oe,
   input  logic core_do,
   input  logic chain_bit,
   output logic pad_oe,
   output logic pad_do
);

   logic shift_oe;
   logic shift_do;

   generate
      if (ROLE == ROLE_SO) begin : g_so
         assign shift_oe = 1'b1;
         assign shift_do = chain_bit;
      end else begin : g_other
         assign shift_oe = 1'b0;
         assign shift_do = core_do;
      end
   endgenerate

   always_comb begin
      if (!test_mode) begin
         pad_oe = core_oe;
         pad_do = core_do;
      end else begin
         pad_do = shift ? shift_do : core_do;
         if (force_in)   pad_oe = 1'b0;
         else if (shift) pad_oe = shift_oe;
         else            pad_oe = core_oe;
      end
   end

endmodule

// File: rtl/padtest_dir_ctrl.sv
module padtest_dir_ctrl
   import padtest_pkg::*;
#(
   parameter int NUM_PADS   = 8,
   parameter int NUM_CHAINS = 2,
   parameter int SO_BASE    = 0,
   parameter int SI_BASE    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  test_mode,
   input  logic                  scan_en,
   input  logic                  tri_inhibit,
   input  logic                  cap_start,
   input  logic [NUM_PADS-1:0]   core_oe,
   input  logic [NUM_PADS-1:0]   core_do,
   input  logic [NUM_CHAINS-1:0] chain_so,
   input  logic [NUM_PADS-1:0]   pad_di,
   output logic [NUM_PADS-1:0]   pad_oe,
   output logic [NUM_PADS-1:0]   pad_do,
   output logic [NUM_CHAINS-1:0] chain_si,
   output logic                  cap_clk_en,
   output logic                  cap_done
);

   localparam int SO_LAST = SO_BASE + NUM_CHAINS - 1;
   localparam int SI_LAST = SI_BASE + NUM_CHAINS - 1;

   generate
      if (NUM_CHAINS < 1) begin : g_bad_chains
         $error("NUM_CHAINS must be at least 1");
      end
      if (SO_LAST >= NUM_PADS || SI_LAST >= NUM_PADS) begin : g_bad_range
         $error("scan port pads exceed NUM_PADS");
      end
      if (!(SO_LAST < SI_BASE || SI_LAST < SO_BASE)) begin : g_bad_overlap
         $error("scan-out and scan-in pad ranges overlap");
      end
   endgenerate

   cap_phase_e phase;
   logic       seq_inhibit;
   logic       force_in;

   padtest_phase_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_ok    (cap_start & test_mode),
      .phase       (phase),
      .seq_inhibit (seq_inhibit),
      .cap_clk_en  (cap_clk_en),
      .cap_done    (cap_done)
   );

   assign force_in = tri_inhibit | seq_inhibit;

   generate
      for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
         localparam pad_role_e R = role_of(i, SO_BASE, SI_BASE, NUM_CHAINS);
         if (R == ROLE_SO) begin : g_so
            padtest_pad_slice #(.ROLE(R)) u_slice (
               .test_mode (test_mode),
               .shift     (scan_en),
               .force_in  (force_in),
               .core_oe   (core_oe[i]),
               .core_do   (core_do[i]),
               .chain_bit (chain_so[i-SO_BASE]),
               .pad_oe    (pad_oe[i]),
               .pad_do    (pad_do[i])
            );
         end else begin : g_nso
            padtest_pad_slice #(.ROLE(R)) u_slice (
               .test_mode (test_mode),
               .shift     (scan_en),
               .force_in  (force_in),
               .core_oe   (core_oe[i]),
               .core_do   (core_do[i]),
               .chain_bit (1'b0),
               .pad_oe    (pad_oe[i]),
               .pad_do    (pad_do[i])
            );
         end
      end
      for (genvar k = 0; k < NUM_CHAINS; k++) begin : g_tap
         assign chain_si[k] = pad_di[SI_BASE+k];
      end
   endgenerate

   logic unused_phase;
   assign unused_phase = ^phase;

endmodule

// File: rtl/padtest_chk.sv
module padtest_chk #(
   parameter int NUM_PADS   = 8,
   parameter int NUM_CHAINS = 2,
   parameter int SO_BASE    = 0,
   parameter int SI_BASE    = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  test_mode,
   input logic                  scan_en,
   input logic                  tri_inhibit,
   input logic                  cap_start,
   input logic [NUM_PADS-1:0]   core_oe,
   input logic [NUM_PADS-1:0]   core_do,
   input logic [NUM_CHAINS-1:0] chain_so,
   input logic [NUM_PADS-1:0]   pad_di,
   input logic [NUM_PADS-1:0]   pad_oe,
   input logic [NUM_PADS-1:0]   pad_do,
   input logic [NUM_CHAINS-1:0] chain_si,
   input logic                  cap_clk_en,
   input logic                  cap_done
);

   localparam logic [NUM_PADS-1:0] SO_MASK =
      NUM_PADS'(((1 << NUM_CHAINS) - 1) << SO_BASE);

   logic [NUM_PADS-1:0] so_placed;
   assign so_placed = NUM_PADS'(chain_so) << SO_BASE;

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !test_mode |-> (pad_oe == core_oe && pad_do == core_do)); // R1
   AST_INHIBIT_ALL_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && tri_inhibit) |-> (pad_oe == '0)); // R2
   AST_SHIFT_ONLY_SO: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && scan_en) |-> ((pad_oe & ~SO_MASK) == '0)); // R3
   AST_SHIFT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && scan_en) |-> ((pad_do & SO_MASK) == so_placed)); // R3
   AST_CLK_ALL_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && cap_clk_en) |-> (pad_oe == '0)); // R7
   AST_CLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_clk_en |=> !cap_clk_en); // R8
   AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      cap_clk_en |=> cap_done); // R9
   AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_done |-> $past(cap_clk_en)); // R9

   logic unused_chk;
   assign unused_chk = ^{cap_start, pad_di, chain_si};

endmodule

bind padtest_dir_ctrl padtest_chk #(
   .NUM_PADS   (NUM_PADS),
   .NUM_CHAINS (NUM_CHAINS),
   .SO_BASE    (SO_BASE),
   .SI_BASE    (SI_BASE)
) chk_i (.*);

// File: tb/padtest_dir_ctrl_tb_top.sv
module padtest_dir_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int C  = 2;
   localparam int SO = 0;
   localparam int SI = 4;
   localparam logic [N-1:0] SO_MASK = N'(((1 << C) - 1) << SO);

   logic clk = 1'b0;
   logic rst_n = 1'b0, test_mode = 1'b0, scan_en = 1'b0, tri_inhibit = 1'b0, cap_start = 1'b0;
   logic [N-1:0] core_oe = '0, core_do = '0, pad_di = '0;
   logic [C-1:0] chain_so = '0;
   logic [N-1:0] pad_oe, pad_do;
   logic [C-1:0] chain_si;
   logic cap_clk_en, cap_done;

   always #(CLK_PERIOD/2) clk = ~clk;

   padtest_dir_ctrl #(.NUM_PADS(N), .NUM_CHAINS(C), .SO_BASE(SO), .SI_BASE(SI)) dut_i (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_en(scan_en),
      .tri_inhibit(tri_inhibit), .cap_start(cap_start), .core_oe(core_oe),
      .core_do(core_do), .chain_so(chain_so), .pad_di(pad_di), .pad_oe(pad_oe),
      .pad_do(pad_do), .chain_si(chain_si), .cap_clk_en(cap_clk_en), .cap_done(cap_done));

   typedef struct {
      logic [N-1:0] oe;
      logic [N-1:0] dout;
      logic [C-1:0] si;
      logic         cen;
      logic         done;
      string        tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // bench model state (phase 0 idle, 1 strobe, 2 wait, 3 clock)
   int   m_ph = 0;
   logic m_done = 0;
   logic p_rst = 0, p_tm = 0, p_st = 0;

   task automatic step(input logic rst, input logic tm, input logic se, input logic inh,
                       input logic st, input logic [N-1:0] coe, input logic [N-1:0] cdo,
                       input logic [N-1:0] pdi, input logic [C-1:0] so, input string tag);
      exp_t e;
      @(posedge clk);
      if (!p_rst) begin
         m_ph = 0; m_done = 0;
      end else begin
         m_done = (m_ph == 3);
         if (m_ph == 0) m_ph = (p_st && p_tm) ? 1 : 0;
         else if (m_ph == 3) m_ph = 0;
         else m_ph = m_ph + 1;
      end
      #1;
      rst_n = rst; test_mode = tm; scan_en = se; tri_inhibit = inh; cap_start = st;
      core_oe = coe; core_do = cdo; pad_di = pdi; chain_so = so;
      p_rst = rst; p_tm = tm; p_st = st;
      e.dout = cdo;
      if (tm && se) e.dout[SO +: C] = so;
      if (!tm)                      e.oe = coe;
      else if (inh || m_ph >= 2)    e.oe = '0;
      else if (se)                  e.oe = SO_MASK;
      else                          e.oe = coe;
      e.si   = pdi[SI +: C];
      e.cen  = (m_ph == 3);
      e.done = m_done;
      e.tag  = tag;
      q.push_back(e);
   endtask

   always @(negedge clk) begin
      if (q.size() != 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (pad_oe !== e.oe || pad_do !== e.dout || chain_si !== e.si ||
             cap_clk_en !== e.cen || cap_done !== e.done) begin
            failures++;
            $display("FAIL %s: actual oe=%b do=%b si=%b cen=%b done=%b expected oe=%b do=%b si=%b cen=%b done=%b",
                     e.tag, pad_oe, pad_do, chain_si, cap_clk_en, cap_done,
                     e.oe, e.dout, e.si, e.cen, e.done);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R11 reset state
      step(0,0,0,0,0, 8'hA5, 8'h3C, 8'h00, 2'b00, "R11 reset");
      step(0,0,0,0,0, 8'h5A, 8'hC3, 8'h10, 2'b00, "R11 reset");
      // R1 mission pass-through, test inputs ignored
      step(1,0,1,1,1, 8'h0F, 8'hF0, 8'h20, 2'b11, "R1 pass");
      step(1,0,1,0,0, 8'hF0, 8'h0F, 8'h30, 2'b01, "R1 pass");
      step(1,0,0,1,0, 8'h81, 8'h7E, 8'h00, 2'b10, "R1 pass");
      step(1,0,0,0,0, 8'hFF, 8'h55, 8'h00, 2'b00, "R1 no capture");
      step(1,0,0,0,0, 8'h00, 8'hAA, 8'h00, 2'b00, "R1 no capture");
      // R10 test mode idle pass-through
      step(1,1,0,0,0, 8'h3C, 8'h96, 8'h00, 2'b11, "R10 idle");
      step(1,1,0,0,0, 8'hC3, 8'h69, 8'h00, 2'b00, "R10 idle");
      // R3 / R4 shift
      step(1,1,1,0,0, 8'hFF, 8'h00, 8'h10, 2'b01, "R3 shift");
      step(1,1,1,0,0, 8'h00, 8'hFF, 8'h20, 2'b10, "R3 shift");
      step(1,1,1,0,0, 8'hFF, 8'h5A, 8'h30, 2'b11, "R4 tap");
      step(1,1,1,0,0, 8'hAA, 8'h00, 8'hCF, 2'b00, "R4 tap");
      // R2 inhibit, alone and together with shift
      step(1,1,0,1,0, 8'hFF, 8'h12, 8'h00, 2'b00, "R2 inhibit");
      step(1,1,1,1,0, 8'hFF, 8'h34, 8'h00, 2'b11, "R2 inhibit+shift");
      step(1,1,1,1,0, 8'h0F, 8'h56, 8'h00, 2'b01, "R2 inhibit+shift");
      // capture sequence
      step(1,1,0,0,1, 8'hF0, 8'h11, 8'h00, 2'b00, "R5 start");
      step(1,1,0,0,0, 8'h3C, 8'h22, 8'h00, 2'b00, "R6 strobe");
      step(1,1,0,0,0, 8'hFF, 8'h33, 8'h00, 2'b00, "R7 wait");
      step(1,1,0,0,0, 8'hFF, 8'h44, 8'h30, 2'b00, "R8 clock");
      step(1,1,0,0,0, 8'hFF, 8'h55, 8'h00, 2'b00, "R9 done");
      step(1,1,0,0,0, 8'hFF, 8'h66, 8'h00, 2'b00, "R9 done low");
      // start while busy is ignored; shift during wait
      step(1,1,0,0,1, 8'h0F, 8'h01, 8'h00, 2'b00, "R5 start2");
      step(1,1,0,0,1, 8'h0F, 8'h02, 8'h00, 2'b00, "R5 busy start");
      step(1,1,1,0,1, SO_MASK, 8'h03, 8'h00, 2'b11, "R7 wait+shift");
      step(1,1,0,0,0, 8'hFF, 8'h04, 8'h00, 2'b00, "R8 clock2");
      step(1,1,0,0,0, 8'hFF, 8'h05, 8'h00, 2'b00, "R9 done2");
      step(1,1,0,0,0, 8'hFF, 8'h06, 8'h00, 2'b00, "R5 no retrigger");
      step(1,1,0,0,0, 8'hFF, 8'h07, 8'h00, 2'b00, "R5 no retrigger");
      // reset in the middle of a capture
      step(1,1,0,0,1, 8'hFF, 8'h08, 8'h00, 2'b00, "R5 start3");
      step(1,1,0,0,0, 8'hFF, 8'h09, 8'h00, 2'b00, "R6 strobe3");
      step(0,1,0,0,0, 8'hFF, 8'h0A, 8'h00, 2'b00, "R7 wait before reset");
      step(1,1,0,0,0, 8'hFF, 8'h0B, 8'h00, 2'b00, "R11 mid reset");
      step(1,1,0,0,0, 8'hFF, 8'h0C, 8'h00, 2'b00, "R11 mid reset");
      repeat (2) @(negedge clk);
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule